// File: doc/BRIEF.md
# Graphics Command Dispatcher

This block sits between a show-ahead instruction FIFO and a set of drawing units in a small graphics engine. Each FIFO word holds a command code in its upper four bits and a parameter field below it. The dispatcher decodes each word and acts on it in one of two ways. Setup commands write a small register file: two coordinate points, a layer select and an overlay visibility flag. Drawing commands start exactly one drawing unit through a start/active/finished handshake.

While a drawing unit is running, the dispatcher stops reading the FIFO. The host can queue many commands and move on, and the drawing order stays strictly sequential. The parameter word, including its color fields, is passed to the unit that was started. It is held only for as long as that unit is active and is not remembered afterwards. The drawing units are outside this block. They read the coordinate and layer registers directly from its outputs.

Top module: `gfx_cmd_dispatch`

## Requirements
- R1: After reset, `layer_bg` is 1 (background selected), `fg_show` is 1, all four coordinate outputs are 0, and `fn_start`, `fn_active` and `fn_param` are all zero.
- R2: An instruction is `{opcode[3:0], parameter}`, with the opcode in the top four bits of `fifo_data`. `fifo_pop` is high in every cycle in which no unit is active, reset is low and the FIFO is not empty, so setup and ignored commands are consumed at one per cycle.
- R3: Opcode 1 loads point 1 and opcode 2 loads point 2. For both, X is taken from `parameter[X_W-1:0]` and Y from the next `Y_W` bits. The new value is visible in the cycle after the pop.
- R4: Opcode 7 loads `layer_bg` from `parameter[0]` (0 selects foreground, 1 selects background). Opcode 9 loads `fg_show` from `parameter[0]`.
- R5: Setup commands (opcodes 1, 2, 7 and 9) never raise any `fn_start` or `fn_active` bit, and no register changes in a cycle without a pop.
- R6: Opcodes 0 and 12 to 15 are popped and leave every register and unit output unchanged.
- R7: Drawing opcodes start unit indices as follows: 3→0, 4→1, 5→2, 6→3, 8→4, 10→5, 11→6. In the cycle after the pop, exactly that `fn_start` bit is high, and only for that one cycle.
- R8: The matching `fn_active` bit rises together with `fn_start`. It stays high until the clock edge at which that unit's `fn_done` bit is sampled high, and it is low in the next cycle.
- R9: While any `fn_active` bit is high, `fifo_pop` stays low even when the FIFO holds data.
- R10: A `fn_done` bit for a unit that is not active, including any `fn_done` bit while no unit is active, has no effect.
- R11: `fn_param` carries the started command's parameter word from the start cycle for as long as the unit is active, and is zero otherwise. `fn_red`, `fn_green` and `fn_blue` are its bit fields `[3*CW-1:2*CW]`, `[2*CW-1:CW]` and `[CW-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_data | input | 4+PARAM_W | Head word of the instruction FIFO (show-ahead) |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_pop | output | 1 | Consume the head word at this clock edge |
| fn_start | output | 7 | One-cycle start pulse per drawing unit |
| fn_active | output | 7 | Per-unit busy indication |
| fn_done | input | 7 | Per-unit finished indication |
| fn_param | output | PARAM_W | Parameter word of the running command |
| fn_red | output | CW | Red field of the running command |
| fn_green | output | CW | Green field of the running command |
| fn_blue | output | CW | Blue field of the running command |
| p1_x | output | X_W | Point 1 X |
| p1_y | output | Y_W | Point 1 Y |
| p2_x | output | X_W | Point 2 X |
| p2_y | output | Y_W | Point 2 Y |
| layer_bg | output | 1 | Layer select, 1 = background |
| fg_show | output | 1 | Overlay visibility |

## Verification
Setup results appear one cycle after the pop edge. A start pulse and the first cycle of active also appear one cycle after the pop. When a stub unit is programmed for a delay of d, its finished bit rises d+1 cycles after the start. Active is then expected low d+3 cycles after the pop, and the instruction queued behind it is popped in that same cycle, so its effect is due one cycle later. The bench drives and samples on falling edges and counts these cycles explicitly for every one of the sixteen opcodes and every parameter value. It checks each output in each of the cycles listed above, both with and without finished bits raised by idle units.

// File: rtl/gfx_cmd_pkg.sv
package gfx_cmd_pkg;

  localparam int OPC_W     = 4;
  localparam int NUM_UNITS = 7;

  typedef enum logic [OPC_W-1:0] {
    OPC_NOP    = 4'd0,
    OPC_SET_P1 = 4'd1,
    OPC_SET_P2 = 4'd2,
    OPC_CLEAR  = 4'd3,
    OPC_RECT   = 4'd4,
    OPC_LINE   = 4'd5,
    OPC_IMAGE  = 4'd6,
    OPC_LAYER  = 4'd7,
    OPC_CRECT  = 4'd8,
    OPC_FGVIS  = 4'd9,
    OPC_FONT   = 4'd10,
    OPC_TEXT   = 4'd11
  } opc_e;

  // Opcode owned by each drawing unit, unit 0 in the low nibble.
  localparam logic [NUM_UNITS*OPC_W-1:0] UNIT_OPC_TBL = {
    OPC_TEXT, OPC_FONT, OPC_CRECT, OPC_IMAGE, OPC_LINE, OPC_RECT, OPC_CLEAR
  };

  typedef struct packed {
    logic                 set_p1;
    logic                 set_p2;
    logic                 set_layer;
    logic                 set_fgvis;
    logic [NUM_UNITS-1:0] unit_sel;
  } dec_t;

endpackage

// File: rtl/gfx_cmd_decode.sv
module gfx_cmd_decode
  import gfx_cmd_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output dec_t             dec
);

  logic [NUM_UNITS-1:0] hit;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    assign hit[u] = (opc == UNIT_OPC_TBL[u*OPC_W +: OPC_W]);
  end

  always_comb begin
    dec          = '0;
    dec.unit_sel = hit;
    case (opc)
      OPC_SET_P1: dec.set_p1    = 1'b1;
      OPC_SET_P2: dec.set_p2    = 1'b1;
      OPC_LAYER:  dec.set_layer = 1'b1;
      OPC_FGVIS:  dec.set_fgvis = 1'b1;
      default:    ;
    endcase
  end

endmodule

// File: rtl/gfx_cmd_regs.sv
module gfx_cmd_regs #(
  parameter int X_W     = 10,
  parameter int Y_W     = 10,
  parameter int PARAM_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               set_p1,
  input  logic               set_p2,
  input  logic               set_layer,
  input  logic               set_fgvis,
  input  logic [PARAM_W-1:0] param,
  output logic [X_W-1:0]     p1_x,
  output logic [Y_W-1:0]     p1_y,
  output logic [X_W-1:0]     p2_x,
  output logic [Y_W-1:0]     p2_y,
  output logic               layer_bg,
  output logic               fg_show
);

  localparam int NPT = 2;

  logic [NPT-1:0] pt_we;
  logic [X_W-1:0] pt_x [NPT];
  logic [Y_W-1:0] pt_y [NPT];

  assign pt_we = {set_p2, set_p1};

  for (genvar k = 0; k < NPT; k++) begin : g_pt
    always_ff @(posedge clk) begin
      if (rst) begin
        pt_x[k] <= '0;
        pt_y[k] <= '0;
      end else if (en && pt_we[k]) begin
        pt_x[k] <= param[X_W-1:0];
        pt_y[k] <= param[X_W +: Y_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      layer_bg <= 1'b1;
      fg_show  <= 1'b1;
    end else if (en) begin
      if (set_layer) layer_bg <= param[0];
      if (set_fgvis) fg_show  <= param[0];
    end
  end

  assign p1_x = pt_x[0];
  assign p1_y = pt_y[0];
  assign p2_x = pt_x[1];
  assign p2_y = pt_y[1];

endmodule

// File: rtl/gfx_unit_seq.sv
module gfx_unit_seq #(
  parameter int NU      = 7,
  parameter int PARAM_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [NU-1:0]      unit_sel,
  input  logic [PARAM_W-1:0] param,
  input  logic [NU-1:0]      fn_done,
  output logic [NU-1:0]      fn_start,
  output logic [NU-1:0]      fn_active,
  output logic [PARAM_W-1:0] fn_param,
  output logic               busy
);

  logic unit_finished;

  assign busy          = |fn_active;
  assign unit_finished = |(fn_active & fn_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      fn_start  <= '0;
      fn_active <= '0;
      fn_param  <= '0;
    end else begin
      fn_start <= '0;
      if (busy) begin
        if (unit_finished) begin
          fn_active <= '0;
          fn_param  <= '0;
        end
      end else if (fire && |unit_sel) begin
        fn_start  <= unit_sel;
        fn_active <= unit_sel;
        fn_param  <= param;
      end
    end
  end

endmodule

// File: rtl/gfx_cmd_dispatch.sv
module gfx_cmd_dispatch
  import gfx_cmd_pkg::*;
#(
  parameter  int X_W     = 10,
  parameter  int Y_W     = 10,
  parameter  int CW      = 5,
  localparam int PARAM_W = ((X_W + Y_W) > (3 * CW)) ? (X_W + Y_W) : (3 * CW),
  localparam int INSTR_W = OPC_W + PARAM_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [INSTR_W-1:0]   fifo_data,
  input  logic                 fifo_empty,
  output logic                 fifo_pop,
  output logic [NUM_UNITS-1:0] fn_start,
  output logic [NUM_UNITS-1:0] fn_active,
  input  logic [NUM_UNITS-1:0] fn_done,
  output logic [PARAM_W-1:0]   fn_param,
  output logic [CW-1:0]        fn_red,
  output logic [CW-1:0]        fn_green,
  output logic [CW-1:0]        fn_blue,
  output logic [X_W-1:0]       p1_x,
  output logic [Y_W-1:0]       p1_y,
  output logic [X_W-1:0]       p2_x,
  output logic [Y_W-1:0]       p2_y,
  output logic                 layer_bg,
  output logic                 fg_show
);

  logic [OPC_W-1:0]   opc;
  logic [PARAM_W-1:0] param;
  dec_t               dec;
  logic               busy;

  assign opc      = fifo_data[INSTR_W-1 -: OPC_W];
  assign param    = fifo_data[PARAM_W-1:0];
  assign fifo_pop = !rst && !busy && !fifo_empty;

  gfx_cmd_decode dec_i (
    .opc (opc),
    .dec (dec)
  );

  gfx_cmd_regs #(
    .X_W     (X_W),
    .Y_W     (Y_W),
    .PARAM_W (PARAM_W)
  ) regs_i (
    .clk       (clk),
    .rst       (rst),
    .en        (fifo_pop),
    .set_p1    (dec.set_p1),
    .set_p2    (dec.set_p2),
    .set_layer (dec.set_layer),
    .set_fgvis (dec.set_fgvis),
    .param     (param),
    .p1_x      (p1_x),
    .p1_y      (p1_y),
    .p2_x      (p2_x),
    .p2_y      (p2_y),
    .layer_bg  (layer_bg),
    .fg_show   (fg_show)
  );

  gfx_unit_seq #(
    .NU      (NUM_UNITS),
    .PARAM_W (PARAM_W)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .fire      (fifo_pop),
    .unit_sel  (dec.unit_sel),
    .param     (param),
    .fn_done   (fn_done),
    .fn_start  (fn_start),
    .fn_active (fn_active),
    .fn_param  (fn_param),
    .busy      (busy)
  );

  assign fn_red   = fn_param[2*CW +: CW];
  assign fn_green = fn_param[CW +: CW];
  assign fn_blue  = fn_param[0 +: CW];

endmodule

// File: rtl/gfx_cmd_dispatch_chk.sv
module gfx_cmd_dispatch_chk
  import gfx_cmd_pkg::*;
#(
  parameter  int X_W     = 10,
  parameter  int Y_W     = 10,
  parameter  int CW      = 5,
  localparam int PARAM_W = ((X_W + Y_W) > (3 * CW)) ? (X_W + Y_W) : (3 * CW)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [OPC_W-1:0]     opc,
  input logic                 fifo_empty,
  input logic                 fifo_pop,
  input logic [NUM_UNITS-1:0] fn_start,
  input logic [NUM_UNITS-1:0] fn_active,
  input logic [NUM_UNITS-1:0] fn_done,
  input logic [PARAM_W-1:0]   fn_param,
  input logic [X_W-1:0]       p1_x,
  input logic [Y_W-1:0]       p1_y,
  input logic [X_W-1:0]       p2_x,
  input logic [Y_W-1:0]       p2_y,
  input logic                 layer_bg,
  input logic                 fg_show
);

  logic                         ignored_opc;
  logic [2*X_W+2*Y_W+1:0]       reg_state;

  assign ignored_opc = (opc == OPC_NOP) || (opc > OPC_TEXT);
  assign reg_state   = {p1_x, p1_y, p2_x, p2_y, layer_bg, fg_show};

  assert_pop_when_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!fifo_empty && fn_active == '0) |-> fifo_pop);

  assert_regs_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !fifo_pop |=> $stable(reg_state));

  assert_ignored_opcode_R6: assert property (@(posedge clk) disable iff (rst)
    (fifo_pop && ignored_opc) |=> ($stable(reg_state) && fn_start == '0));

  assert_start_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fn_start));

  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (fn_start != '0) |=> (fn_start == '0));

  assert_start_sets_active_R8: assert property (@(posedge clk) disable iff (rst)
    (fn_start != '0) |-> (fn_active == fn_start));

  assert_active_release_R8: assert property (@(posedge clk) disable iff (rst)
    ((fn_active & fn_done) != '0) |=> (fn_active == '0));

  assert_no_pop_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (fn_active != '0) |-> !fifo_pop);

  assert_foreign_done_ignored_R10: assert property (@(posedge clk) disable iff (rst)
    ((fn_active != '0) && ((fn_active & fn_done) == '0)) |=> $stable(fn_active));

  assert_param_cleared_idle_R11: assert property (@(posedge clk) disable iff (rst)
    (fn_active == '0) |-> (fn_param == '0));

endmodule

bind gfx_cmd_dispatch gfx_cmd_dispatch_chk #(
  .X_W (X_W),
  .Y_W (Y_W),
  .CW  (CW)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .opc        (opc),
  .fifo_empty (fifo_empty),
  .fifo_pop   (fifo_pop),
  .fn_start   (fn_start),
  .fn_active  (fn_active),
  .fn_done    (fn_done),
  .fn_param   (fn_param),
  .p1_x       (p1_x),
  .p1_y       (p1_y),
  .p2_x       (p2_x),
  .p2_y       (p2_y),
  .layer_bg   (layer_bg),
  .fg_show    (fg_show)
);

// File: tb/gfx_cmd_dispatch_tb_top.sv
module gfx_cmd_dispatch_tb_top;

  localparam int X_W = 3;
  localparam int Y_W = 3;
  localparam int CW  = 2;
  localparam int PW  = 6;
  localparam int IW  = 10;
  localparam int NU  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  // Show-ahead FIFO model
  logic [IW-1:0] q_mem [16];
  logic [3:0]    q_rd = '0;
  logic [3:0]    q_wr = '0;
  logic          fifo_empty;
  logic [IW-1:0] fifo_data;
  logic          fifo_pop;
  assign fifo_empty = (q_rd == q_wr);
  assign fifo_data  = q_mem[q_rd];
  always @(posedge clk) if (fifo_pop) q_rd <= q_rd + 4'd1;

  logic [NU-1:0] fn_start, fn_active, fn_done;
  logic [NU-1:0] spur = '0;
  logic [PW-1:0] fn_param;
  logic [CW-1:0] fn_red, fn_green, fn_blue;
  logic [X_W-1:0] p1_x, p2_x;
  logic [Y_W-1:0] p1_y, p2_y;
  logic layer_bg, fg_show;

  // Drawing-unit stubs: finish after a programmable delay
  logic [3:0] dly = '0;
  logic [3:0] cnt [NU];
  always @(posedge clk) begin
    for (int i = 0; i < NU; i++) begin
      if (fn_start[i]) cnt[i] <= dly;
      else if (fn_active[i] && cnt[i] != 4'd0) cnt[i] <= cnt[i] - 4'd1;
    end
  end
  always_comb begin
    for (int i = 0; i < NU; i++)
      fn_done[i] = (fn_active[i] && !fn_start[i] && cnt[i] == 4'd0) || spur[i];
  end

  gfx_cmd_dispatch #(.X_W(X_W), .Y_W(Y_W), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
    .fifo_pop(fifo_pop), .fn_start(fn_start), .fn_active(fn_active),
    .fn_done(fn_done), .fn_param(fn_param), .fn_red(fn_red),
    .fn_green(fn_green), .fn_blue(fn_blue), .p1_x(p1_x), .p1_y(p1_y),
    .p2_x(p2_x), .p2_y(p2_y), .layer_bg(layer_bg), .fg_show(fg_show)
  );

  int n_chk = 0;
  int n_err = 0;
  int e_x1 = 0, e_y1 = 0, e_x2 = 0, e_y2 = 0, e_layer = 1, e_fg = 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push(input int op, input int prm);
    q_mem[q_wr] = IW'((op << PW) | prm);
    q_wr = q_wr + 4'd1;
  endtask

  function automatic int unit_of(input int op);
    case (op)
      3: return 0;  4: return 1;  5: return 2;  6: return 3;
      8: return 4;  10: return 5; 11: return 6;
      default: return -1;
    endcase
  endfunction

  task automatic chk_regs(input string req);
    chk(req, "p1_x", int'(p1_x), e_x1);
    chk(req, "p1_y", int'(p1_y), e_y1);
    chk(req, "p2_x", int'(p2_x), e_x2);
    chk(req, "p2_y", int'(p2_y), e_y2);
    chk(req, "layer_bg", int'(layer_bg), e_layer);
    chk(req, "fg_show", int'(fg_show), e_fg);
  endtask

  task automatic run_instr(input int op, input int prm, input int d, input bit use_spur);
    int u, fol, oh;
    u   = unit_of(op);
    fol = (prm * 5 + 3) % 64;
    oh  = (u >= 0) ? (1 << u) : 0;
    dly = 4'(d);
    @(negedge clk);
    push(op, prm);
    push(1, fol);
    if (use_spur) spur = NU'(~oh);
    #1;
    chk("R2", "pop with queued word", int'(fifo_pop), 1);
    @(negedge clk);
    if (u >= 0) begin
      chk("R7", "start pulse", int'(fn_start), oh);
      chk("R8", "active rises", int'(fn_active), oh);
      chk("R9", "no pop in start cycle", int'(fifo_pop), 0);
      chk("R11", "param word", int'(fn_param), prm);
      chk("R11", "red", int'(fn_red), (prm >> (2*CW)) & 3);
      chk("R11", "green", int'(fn_green), (prm >> CW) & 3);
      chk("R11", "blue", int'(fn_blue), prm & 3);
      for (int k = 2; k <= d + 2; k++) begin
        @(negedge clk);
        chk("R7", "start one cycle", int'(fn_start), 0);
        chk(use_spur ? "R10" : "R8", "active held", int'(fn_active), oh);
        chk("R9", "no pop while busy", int'(fifo_pop), 0);
        chk("R11", "param held", int'(fn_param), prm);
      end
      @(negedge clk);
      chk("R8", "active falls", int'(fn_active), 0);
      chk("R11", "param cleared", int'(fn_param), 0);
      chk("R2", "pop resumes", int'(fifo_pop), 1);
      spur = '0;
      chk_regs("R5");
    end else begin
      chk(op == 0 || op > 11 ? "R6" : "R5", "no start", int'(fn_start), 0);
      chk(op == 0 || op > 11 ? "R6" : "R5", "no active", int'(fn_active), 0);
      chk("R2", "back-to-back pop", int'(fifo_pop), 1);
      case (op)
        1: begin e_x1 = prm & 7; e_y1 = (prm >> X_W) & 7; end
        2: begin e_x2 = prm & 7; e_y2 = (prm >> X_W) & 7; end
        7: e_layer = prm & 1;
        9: e_fg = prm & 1;
        default: ;
      endcase
      if (op == 1 || op == 2) chk_regs("R3");
      else if (op == 7 || op == 9) chk_regs("R4");
      else chk_regs("R6");
      spur = '0;
    end
    @(negedge clk);
    e_x1 = fol & 7;
    e_y1 = (fol >> X_W) & 7;
    chk_regs("R2");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk_regs("R1");
    chk("R1", "start", int'(fn_start), 0);
    chk("R1", "active", int'(fn_active), 0);
    chk("R1", "param", int'(fn_param), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_regs("R1");
    // Done while idle must be ignored (R10)
    spur = '1;
    @(negedge clk);
    chk("R10", "idle done no active", int'(fn_active), 0);
    spur = '0;
    for (int op = 0; op < 16; op++)
      for (int prm = 0; prm < 64; prm++)
        run_instr(op, prm, prm % 4, (prm % 8) >= 4);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule